// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block keeps the interrupt state of a UART that has nine interrupt sources and drives one combined, registered interrupt line. It watches the TX and RX FIFO fill levels, the TX FIFO empty flag, a transmitter-busy flag and five one-cycle receive error pulses. From these it derives three level bits that follow the hardware every cycle and six sticky event bits that software clears by writing 1. A per-source enable mask selects which state bits reach the interrupt line.

Two programmable trigger codes turn into FIFO-level thresholds. The TX watermark fires while the TX level is strictly below its threshold. The RX watermark fires while the RX level is at or above its threshold. A small word-wide register port reads the state, enable, test and trigger registers and writes them. A test register lets software force any state bit to 1. The FIFOs, the serial engines and the bus fabric sit outside this block.

Register selector values (`wr_addr` and `rd_addr`): 0 selects the state register, 1 the enable register, 2 the test register and 3 the trigger register.

Top module: `uart_irq_ctrl`

## Requirements
- R1: State bit positions are: 0 tx watermark, 1 rx watermark, 2 tx done, 3 rx overflow, 4 rx frame error, 5 rx break, 6 rx timeout, 7 rx parity error, 8 tx empty. State bits 31:9 read as zero. After reset the state reads 0x101 and the enable, test and trigger registers read 0.
- R2: State bit 0 is 1 when the TX level sampled at the previous clock edge was strictly less than the TX threshold. The TX trigger code maps 0→1, 1→2, 2→4, 3→8, 4→16, and codes 5 to 7 map to 16.
- R3: State bit 1 is 1 when the RX level sampled at the previous clock edge was greater than or equal to the RX threshold. The RX trigger code maps 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, 6→62, and code 7 maps to 62.
- R4: State bit 8 follows the TX FIFO empty input with a delay of one clock.
- R5: State bit 2 is set on the clock where the transmitter becomes idle, that is, TX FIFO empty and not busy after a cycle where either condition failed. Once set, it stays set until it is cleared.
- R6: A one-cycle pulse on an error input sets the matching sticky bit (3 to 7) at that clock edge. The bit stays set until software clears it.
- R7: Writing 1 to state bits 2 to 7 clears those bits. Writes to bits 0, 1 and 8 have no effect. When a hardware set and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: Writing 1 to a test register bit forces the matching state bit to 1: a sticky bit stays set, and a level bit reads 1 for one cycle. The test register always reads 0.
- R9: `irq_o` is 1 in the cycle after any state bit and the matching enable bit are both 1. Sources that are not enabled never raise it.
- R10: The enable register holds bits 8:0 as read/write. The trigger register keeps the TX code in bits 2:0 and the RX code in bits 6:4. All other bits of both registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for write |
| wr_data | input | REG_W | Write data |
| rd_addr | input | 2 | Register select for read |
| rd_data | output | REG_W | Read data (combinational) |
| tx_lvl | input | LVL_W | TX FIFO fill level |
| rx_lvl | input | LVL_W | RX FIFO fill level |
| tx_fifo_empty | input | 1 | TX FIFO is empty |
| tx_busy | input | 1 | Transmitter is shifting a character |
| rx_overflow_p | input | 1 | RX overflow pulse |
| rx_frame_err_p | input | 1 | RX framing error pulse |
| rx_break_p | input | 1 | RX break pulse |
| rx_timeout_p | input | 1 | RX timeout pulse |
| rx_parity_err_p | input | 1 | RX parity error pulse |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to produce is a hardware event and a software write-1-to-clear landing on the same sticky bit at the same clock edge. The bench drives both from one task in the same low clock phase: it raises a frame-error pulse together with a clear of that bit, then reads the bit back. The tx-done edge is a second awkward case. It is produced by toggling the busy flag while the FIFO stays empty, and the bench also confirms that clearing the bit while the line stays idle does not set it again.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned NUM_SRC  = 9;
   localparam int unsigned NUM_STKY = 6;
   localparam int unsigned CODE_W   = 3;

   localparam int unsigned B_TX_WM  = 0;
   localparam int unsigned B_RX_WM  = 1;
   localparam int unsigned B_TX_DN  = 2;
   localparam int unsigned B_PAR    = 7;
   localparam int unsigned B_TX_EMP = 8;

   typedef enum logic [1:0] {
      REG_STATE  = 2'd0,
      REG_ENABLE = 2'd1,
      REG_TEST   = 2'd2,
      REG_TRIG   = 2'd3
   } reg_sel_e;

   localparam logic [NUM_SRC-1:0] STATE_RST = 9'h101;
endpackage

// File: rtl/uart_irq_wm_level.sv
module uart_irq_wm_level #(
   parameter int unsigned LVL_W    = 7,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned MAX_CODE = 4,
   parameter int unsigned TOP_THR  = 16,
   parameter bit          BELOW    = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   input  logic [LVL_W-1:0]  level,
   output logic              hit
);
   localparam logic [LVL_W-1:0] TOP_V = LVL_W'(TOP_THR);
   localparam logic [CODE_W-1:0] MAXC = CODE_W'(MAX_CODE);

   if (TOP_THR >= (1 << LVL_W)) begin : g_bad_thr
      $error("uart_irq_wm_level: TOP_THR does not fit LVL_W");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("uart_irq_wm_level: MAX_CODE does not fit CODE_W");
   end

   logic [LVL_W-1:0] thr;

   always_comb begin
      if (code >= MAXC) thr = TOP_V;
      else              thr = {{(LVL_W-1){1'b0}}, 1'b1} << code;
   end

   if (BELOW) begin : g_below
      assign hit = (level < thr);
   end else begin : g_at_or_above
      assign hit = (level >= thr);
   end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int unsigned LVL_W = 7,
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [REG_W-1:0] rd_data,
   input  logic [LVL_W-1:0] tx_lvl,
   input  logic [LVL_W-1:0] rx_lvl,
   input  logic             tx_fifo_empty,
   input  logic             tx_busy,
   input  logic             rx_overflow_p,
   input  logic             rx_frame_err_p,
   input  logic             rx_break_p,
   input  logic             rx_timeout_p,
   input  logic             rx_parity_err_p,
   output logic             irq_o
);
   localparam int unsigned TRIG_W = 2 * CODE_W + 1;

   if (REG_W < NUM_SRC) begin : g_bad_regw
      $error("uart_irq_ctrl: REG_W narrower than source count");
   end

   logic unused_wr_hi;
   assign unused_wr_hi = ^wr_data[REG_W-1:NUM_SRC];

   // register write decode
   logic wr_state, wr_enable, wr_test, wr_trig;
   assign wr_state  = wr_en && (wr_addr == REG_STATE);
   assign wr_enable = wr_en && (wr_addr == REG_ENABLE);
   assign wr_test   = wr_en && (wr_addr == REG_TEST);
   assign wr_trig   = wr_en && (wr_addr == REG_TRIG);

   logic [NUM_SRC-1:0] test_pulse;
   assign test_pulse = wr_test ? wr_data[NUM_SRC-1:0] : '0;

   // control registers
   logic [NUM_SRC-1:0] en_q;
   logic [CODE_W-1:0]  tx_code_q, rx_code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= '0;
         tx_code_q <= '0;
         rx_code_q <= '0;
      end else begin
         if (wr_enable) en_q <= wr_data[NUM_SRC-1:0];
         if (wr_trig) begin
            tx_code_q <= wr_data[CODE_W-1:0];
            rx_code_q <= wr_data[CODE_W+1 +: CODE_W];
         end
      end
   end

   // watermark comparisons
   logic tx_hit, rx_hit;

   uart_irq_wm_level #(
      .LVL_W(LVL_W), .CODE_W(CODE_W), .MAX_CODE(4), .TOP_THR(16), .BELOW(1'b1)
   ) u_tx_wm (
      .code(tx_code_q), .level(tx_lvl), .hit(tx_hit)
   );

   uart_irq_wm_level #(
      .LVL_W(LVL_W), .CODE_W(CODE_W), .MAX_CODE(6), .TOP_THR(62), .BELOW(1'b0)
   ) u_rx_wm (
      .code(rx_code_q), .level(rx_lvl), .hit(rx_hit)
   );

   // level bits: {tx_empty, rx_wm, tx_wm}
   logic [2:0] lvl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 3'b101;
      else        lvl_q <= {tx_fifo_empty | test_pulse[B_TX_EMP],
                            rx_hit        | test_pulse[B_RX_WM],
                            tx_hit        | test_pulse[B_TX_WM]};
   end

   // transmitter idle edge
   logic tx_idle, tx_idle_q, done_evt;
   assign tx_idle = tx_fifo_empty & ~tx_busy;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_idle_q <= 1'b1;
      else        tx_idle_q <= tx_idle;
   end
   assign done_evt = tx_idle & ~tx_idle_q;

   // sticky event bits occupy state bits 2..7
   logic [NUM_STKY-1:0] stk_set, stk_clr, stk_q;
   assign stk_set = {rx_parity_err_p, rx_timeout_p, rx_break_p,
                     rx_frame_err_p, rx_overflow_p, done_evt}
                    | test_pulse[B_PAR:B_TX_DN];
   assign stk_clr = wr_state ? wr_data[B_PAR:B_TX_DN] : '0;

   uart_irq_sticky #(.N(NUM_STKY)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(stk_clr), .q(stk_q)
   );

   logic [NUM_SRC-1:0] state_q;
   assign state_q = {lvl_q[2], stk_q, lvl_q[1], lvl_q[0]};

   // combined interrupt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(state_q & en_q);
   end

   // read mux
   logic [TRIG_W-1:0] trig_rd;
   assign trig_rd = {rx_code_q, 1'b0, tx_code_q};

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         REG_STATE:  rd_data[NUM_SRC-1:0] = state_q;
         REG_ENABLE: rd_data[NUM_SRC-1:0] = en_q;
         REG_TEST:   rd_data = '0;
         REG_TRIG:   rd_data[TRIG_W-1:0] = trig_rd;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
   parameter int unsigned REG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [REG_W-1:0] wr_data,
   input logic [1:0]       rd_addr,
   input logic [REG_W-1:0] rd_data,
   input logic             tx_fifo_empty,
   input logic             rx_overflow_p,
   input logic             rx_parity_err_p,
   input logic [8:0]       state_q,
   input logic [8:0]       en_q,
   input logic             irq_o
);
   assert_irq_combine_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(|(state_q & en_q)));

   assert_overflow_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow_p |=> state_q[3]);

   assert_hw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_parity_err_p && wr_en && wr_addr == 2'd0 && wr_data[7]) |=> state_q[7]);

   assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q[7] && !(wr_en && wr_addr == 2'd0 && wr_data[7])) |=> state_q[7]);

   assert_test_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && wr_data[5]) |=> state_q[5]);

   assert_empty_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fifo_empty && !(wr_en && wr_addr == 2'd2)) |=> state_q[8]);

   always_comb begin
      if (rst_n && rd_addr == 2'd2)
         assert_test_reads_zero_R8: assert (rd_data == '0);
   end
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .tx_fifo_empty(tx_fifo_empty), .rx_overflow_p(rx_overflow_p),
   .rx_parity_err_p(rx_parity_err_p), .state_q(state_q), .en_q(en_q),
   .irq_o(irq_o)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
   localparam int LVL_W = 7;
   localparam int REG_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_addr = '0;
   logic [REG_W-1:0] wr_data = '0;
   logic [1:0]       rd_addr = '0;
   logic [REG_W-1:0] rd_data;
   logic [LVL_W-1:0] tx_lvl = '0;
   logic [LVL_W-1:0] rx_lvl = '0;
   logic             tx_fifo_empty = 1'b1;
   logic             tx_busy = 1'b0;
   logic             rx_overflow_p = 1'b0;
   logic             rx_frame_err_p = 1'b0;
   logic             rx_break_p = 1'b0;
   logic             rx_timeout_p = 1'b0;
   logic             rx_parity_err_p = 1'b0;
   logic             irq_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   uart_irq_ctrl #(.LVL_W(LVL_W), .REG_W(REG_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_fifo_empty(tx_fifo_empty),
      .tx_busy(tx_busy), .rx_overflow_p(rx_overflow_p),
      .rx_frame_err_p(rx_frame_err_p), .rx_break_p(rx_break_p),
      .rx_timeout_p(rx_timeout_p), .rx_parity_err_p(rx_parity_err_p),
      .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      step();
      rd(2'd0, v); check("R1 reset state", v, 32'h101);
      rd(2'd1, v); check("R1 reset enable", v, 32'h0);
      rd(2'd3, v); check("R1 reset trigger", v, 32'h0);
      check("R9 reset irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_trig_rb();
      logic [31:0] v;
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, v); check("R10 trigger readback", v, 32'h77);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); check("R10 enable readback", v, 32'h1FF);
      wr(2'd1, 32'h0);
      wr(2'd3, 32'h0);
   endtask

   task automatic t_tx_wm();
      logic [31:0] v;
      wr(2'd3, 32'h2);
      tx_lvl = 7'd3; step();
      rd(2'd0, v); check("R2 tx lvl3 code2", {31'b0, v[0]}, 32'h1);
      tx_lvl = 7'd4; step();
      rd(2'd0, v); check("R2 tx lvl4 code2", {31'b0, v[0]}, 32'h0);
      wr(2'd3, 32'h6);
      tx_lvl = 7'd15; step();
      rd(2'd0, v); check("R2 tx lvl15 reserved code", {31'b0, v[0]}, 32'h1);
      tx_lvl = 7'd16; step();
      rd(2'd0, v); check("R2 tx lvl16 reserved code", {31'b0, v[0]}, 32'h0);
      tx_lvl = 7'd0;
      wr(2'd3, 32'h0);
   endtask

   task automatic t_rx_wm();
      logic [31:0] v;
      rx_lvl = 7'd1; step();
      rd(2'd0, v); check("R3 rx lvl1 code0", {31'b0, v[1]}, 32'h1);
      wr(2'd3, 32'h60);
      rx_lvl = 7'd61; step();
      rd(2'd0, v); check("R3 rx lvl61 code6", {31'b0, v[1]}, 32'h0);
      rx_lvl = 7'd62; step();
      rd(2'd0, v); check("R3 rx lvl62 code6", {31'b0, v[1]}, 32'h1);
      wr(2'd3, 32'h70);
      rd(2'd0, v); check("R3 rx lvl62 code7", {31'b0, v[1]}, 32'h1);
      rx_lvl = 7'd61; step();
      rd(2'd0, v); check("R3 rx lvl61 code7", {31'b0, v[1]}, 32'h0);
      rx_lvl = 7'd0;
      wr(2'd3, 32'h0);
   endtask

   task automatic t_tx_empty_done();
      logic [31:0] v;
      tx_fifo_empty = 1'b0; tx_busy = 1'b1; step();
      rd(2'd0, v); check("R4 tx empty low", {31'b0, v[8]}, 32'h0);
      check("R5 no done while busy", {31'b0, v[2]}, 32'h0);
      tx_fifo_empty = 1'b1; step();
      rd(2'd0, v); check("R4 tx empty high", {31'b0, v[8]}, 32'h1);
      tx_busy = 1'b0; step();
      rd(2'd0, v); check("R5 done on idle", {31'b0, v[2]}, 32'h1);
      wr(2'd0, 32'h104);
      rd(2'd0, v); check("R5 done clears while idle", {31'b0, v[2]}, 32'h0);
      check("R7 level bit not cleared", {31'b0, v[8]}, 32'h1);
   endtask

   task automatic t_errors();
      logic [31:0] v;
      @(negedge clk);
      rx_overflow_p = 1'b1; rx_break_p = 1'b1; rx_parity_err_p = 1'b1;
      @(negedge clk);
      rx_overflow_p = 1'b0; rx_break_p = 1'b0; rx_parity_err_p = 1'b0;
      step();
      rd(2'd0, v); check("R6 sticky errors", v & 32'hF8, 32'hA8);
      wr(2'd0, 32'h28);
      rd(2'd0, v); check("R7 w1c partial", v & 32'hF8, 32'h80);
      rx_timeout_p = 1'b1; step(); rx_timeout_p = 1'b0;
      wr(2'd0, 32'hC0);
      rd(2'd0, v); check("R7 w1c rest", v & 32'hFC, 32'h0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      @(negedge clk);
      rx_frame_err_p = 1'b1;
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h10;
      @(negedge clk);
      rx_frame_err_p = 1'b0; wr_en = 1'b0; wr_data = '0;
      rd(2'd0, v); check("R7 hw set wins", {31'b0, v[4]}, 32'h1);
      wr(2'd0, 32'h10);
   endtask

   task automatic t_test();
      logic [31:0] v;
      wr(2'd2, 32'h22);
      rd(2'd0, v); check("R8 test forces bits", v & 32'h22, 32'h22);
      rd(2'd2, v); check("R8 test reads zero", v, 32'h0);
      step();
      rd(2'd0, v); check("R8 level bit one cycle", {31'b0, v[1]}, 32'h0);
      check("R8 sticky bit stays", {31'b0, v[5]}, 32'h1);
      wr(2'd0, 32'h20);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(2'd1, 32'h8);
      step();
      check("R9 disabled sources quiet", {31'b0, irq_o}, 32'h0);
      @(negedge clk); rx_overflow_p = 1'b1;
      @(negedge clk); rx_overflow_p = 1'b0;
      check("R9 irq one cycle later", {31'b0, irq_o}, 32'h0);
      step();
      check("R9 irq raised", {31'b0, irq_o}, 32'h1);
      wr(2'd0, 32'h8);
      step();
      check("R9 irq drops after clear", {31'b0, irq_o}, 32'h0);
      wr(2'd1, 32'h100);
      step();
      check("R9 tx empty enabled", {31'b0, irq_o}, 32'h1);
      wr(2'd1, 32'h0);
      rd(2'd0, v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_trig_rb();
      t_tx_wm();
      t_rx_wm();
      t_tx_empty_done();
      t_errors();
      t_race();
      t_test();
      t_irq();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule